// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

This block sits beside an out-of-order core's load pipeline. Loads are allocated in program order. They may execute early and in any order, and they retire in order at commit. For every tracked load the block keeps a sequence tag. Once the load has executed, the block also keeps the load's cache-line address and the value it read. The block then looks for evidence that another core changed memory under an early load. When it finds such evidence, it asks the pipeline to squash and replay from the offending load onward.

The detection method is chosen by the mode input. In snoop mode, coherence invalidations and remote-store notifications are matched against the line addresses of executed loads. In replay mode, the oldest load is re-read at commit, and the pipeline presents the new value. The block flags any difference from the value recorded at execute. Either method also covers loads whose address came from a predicted value, because such a load is tracked exactly like any other early load.

Top module: `spec_load_guard`

## Requirements
- R1: After reset, squash_valid_o is low, alloc_ready_o is high and no load is tracked.
- R2: The tracker holds DEPTH loads (default 16). With DEPTH loads tracked, alloc_ready_o is low and an allocation request is ignored. One commit makes room again.
- R3: In snoop mode (mode_i = 0), a snoop hits a tracked executed load when address bits [ADDR_W-1:6] match that load's execute address. The byte offset within the 64-byte line does not matter. On the cycle after a hit, squash_valid_o is high for exactly one cycle and squash_tag_o carries the load's tag. A snoop to any other line raises nothing.
- R4: A load that has been allocated but not yet executed is never hit. A load executing in the same cycle as the snoop is compared using its execute address.
- R5: When several loads hit, the reported tag is the oldest in allocation order. Execution order and the position in the circular storage do not affect this.
- R6: On the clock edge that ends the squash cycle, the reported load and every younger load are removed. Older loads stay tracked.
- R7: A commit frees the oldest load. If a snoop hits that load in the same cycle as its commit, the commit wins: the load is freed and no squash follows from it.
- R8: In replay mode (mode_i = 1), a commit whose commit_data_i differs from the value captured at execute frees nothing. It raises a squash with the oldest load's tag on the next cycle, and then every tracked load is removed. A commit with equal data frees the oldest load.
- R9: In replay mode, snoops have no effect. In snoop mode, commit_data_i has no effect.
- R10: While squash_valid_o is high, alloc_ready_o is low and allocate, execute, commit and snoop inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = snoop matching, 1 = commit-time value replay |
| alloc_valid_i | input | 1 | Allocate a load at the young end |
| alloc_tag_i | input | TAG_W | Sequence tag of the allocated load |
| alloc_ready_o | output | 1 | Allocation accepted this cycle |
| exec_valid_i | input | 1 | A tracked load executes |
| exec_tag_i | input | TAG_W | Tag of the executing load |
| exec_addr_i | input | ADDR_W | Byte address read by the load |
| exec_data_i | input | DATA_W | Value read at execute |
| commit_valid_i | input | 1 | The oldest load commits |
| commit_data_i | input | DATA_W | Value re-read at commit (replay mode) |
| snoop_valid_i | input | 1 | Invalidation or remote store observed |
| snoop_addr_i | input | ADDR_W | Byte address of the snoop |
| squash_valid_o | output | 1 | Squash and replay request |
| squash_tag_o | output | TAG_W | Tag of the oldest violating load |

## Verification
The assertions take several properties of the inputs for granted:
- Tags are unique among tracked loads.
- An execute names a load that is tracked and has not yet executed.
- A commit arrives only when the oldest load has executed, and never targets a load that is executing in that same cycle.
- The mode changes only while nothing is tracked and no squash is pending.
- DEPTH is a power of two.

The stimulus stays within these limits by choosing its targets from the bench's own model of the queue. Tags come from a wrapping counter that is much larger than the queue. The mode is switched only after a drain phase that executes and commits every remaining load.

// File: rtl/spec_load_guard_pkg.sv
package spec_load_guard_pkg;
  typedef enum logic {
    CHK_SNOOP  = 1'b0,
    CHK_REPLAY = 1'b1
  } chk_mode_e;
endpackage

// File: rtl/slg_hit_vec.sv
module slg_hit_vec #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned LINE_W = 26
) (
  input  logic [DEPTH-1:0]             live_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0][TAG_W-1:0]  tag_i,
  input  logic [DEPTH-1:0][LINE_W-1:0] line_i,
  input  logic [DEPTH-1:0]             shield_i,
  input  logic                         exec_valid_i,
  input  logic [TAG_W-1:0]             exec_tag_i,
  input  logic [LINE_W-1:0]            exec_line_i,
  input  logic [LINE_W-1:0]            snoop_line_i,
  output logic [DEPTH-1:0]             exec_sel_o,
  output logic [DEPTH-1:0]             hit_o
);
  logic exec_same_line;
  assign exec_same_line = (exec_line_i == snoop_line_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign exec_sel_o[i] = exec_valid_i && live_i[i] && (tag_i[i] == exec_tag_i);
    // an entry being executed this cycle is judged by its incoming address
    assign hit_o[i] = live_i[i] && !shield_i[i] &&
                      ((done_i[i] && (line_i[i] == snoop_line_i)) ||
                       (exec_sel_o[i] && exec_same_line));
  end
endmodule

// File: rtl/slg_age_pick.sv
module slg_age_pick #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = 4
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [PTR_W-1:0] head_i,
  output logic             found_o,
  output logic [PTR_W-1:0] idx_o
);
  logic [PTR_W-1:0] pos;

  // walk from the oldest slot toward the youngest, first request wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = head_i;
    pos     = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      pos = head_i + PTR_W'(k);
      if (!found_o && req_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard
  import spec_load_guard_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TAG_W      = 6,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              alloc_valid_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  output logic              alloc_ready_o,
  input  logic              exec_valid_i,
  input  logic [TAG_W-1:0]  exec_tag_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic [DATA_W-1:0] exec_data_i,
  input  logic              commit_valid_i,
  input  logic [DATA_W-1:0] commit_data_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              squash_valid_o,
  output logic [TAG_W-1:0]  squash_tag_o
);
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned CNT_W  = PTR_W + 1;
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned LINE_W = ADDR_W - OFF_W;

  logic [PTR_W-1:0]             head_q, tail_q;
  logic [CNT_W-1:0]             count_q;
  logic [DEPTH-1:0]             done_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][LINE_W-1:0] line_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic                         sq_q;
  logic [TAG_W-1:0]             sq_tag_q;
  logic [PTR_W-1:0]             sq_idx_q;

  chk_mode_e        mode;
  logic             active, not_empty, replay_bad, commit_fire, alloc_fire, snoop_det;
  logic [DEPTH-1:0] live, head_oh, shield, exec_sel, hit;
  logic             pick_found;
  logic [PTR_W-1:0] pick_idx, keep_n;
  logic             unused_off;

  assign unused_off = ^{exec_addr_i[OFF_W-1:0], snoop_addr_i[OFF_W-1:0]};

  assign mode      = chk_mode_e'(mode_i);
  assign active    = !sq_q;
  assign not_empty = (count_q != '0);
  assign head_oh   = DEPTH'(1) << head_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    logic [PTR_W-1:0] age;
    assign age     = PTR_W'(i) - head_q;
    assign live[i] = (CNT_W'(age) < count_q);
  end

  assign replay_bad  = active && (mode == CHK_REPLAY) && commit_valid_i && not_empty &&
                       (data_q[head_q] != commit_data_i);
  assign commit_fire = active && commit_valid_i && not_empty && !replay_bad;
  assign alloc_ready_o = active && (count_q != CNT_W'(DEPTH));
  assign alloc_fire  = alloc_valid_i && alloc_ready_o;
  assign shield      = head_oh & {DEPTH{commit_fire}};

  slg_hit_vec #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_hit (
    .live_i      (live),
    .done_i      (done_q),
    .tag_i       (tag_q),
    .line_i      (line_q),
    .shield_i    (shield),
    .exec_valid_i(exec_valid_i && active),
    .exec_tag_i  (exec_tag_i),
    .exec_line_i (exec_addr_i[ADDR_W-1:OFF_W]),
    .snoop_line_i(snoop_addr_i[ADDR_W-1:OFF_W]),
    .exec_sel_o  (exec_sel),
    .hit_o       (hit)
  );

  slg_age_pick #(
    .DEPTH(DEPTH),
    .PTR_W(PTR_W)
  ) u_pick (
    .req_i  (hit),
    .head_i (head_q),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  assign snoop_det = active && (mode == CHK_SNOOP) && snoop_valid_i && pick_found;
  assign keep_n    = sq_idx_q - head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      tail_q   <= '0;
      count_q  <= '0;
      sq_q     <= 1'b0;
      sq_tag_q <= '0;
      sq_idx_q <= '0;
    end else if (sq_q) begin
      // flush the reported load and everything younger
      sq_q    <= 1'b0;
      tail_q  <= sq_idx_q;
      count_q <= CNT_W'(keep_n);
    end else begin
      if (replay_bad) begin
        sq_q     <= 1'b1;
        sq_tag_q <= tag_q[head_q];
        sq_idx_q <= head_q;
      end else if (snoop_det) begin
        sq_q     <= 1'b1;
        sq_tag_q <= tag_q[pick_idx];
        sq_idx_q <= pick_idx;
      end
      if (commit_fire) head_q <= head_q + PTR_W'(1);
      if (alloc_fire)  tail_q <= tail_q + PTR_W'(1);
      count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q[i] <= 1'b0;
      end else if (alloc_fire && (tail_q == PTR_W'(i))) begin
        done_q[i] <= 1'b0;
      end else if (exec_sel[i]) begin
        done_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc_fire && (tail_q == PTR_W'(i))) begin
        tag_q[i] <= alloc_tag_i;
      end else if (exec_sel[i]) begin
        line_q[i] <= exec_addr_i[ADDR_W-1:OFF_W];
        data_q[i] <= exec_data_i;
      end
    end
  end

  assign squash_valid_o = sq_q;
  assign squash_tag_o   = sq_tag_q;
endmodule

// File: rtl/spec_load_guard_chk.sv
module spec_load_guard_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             alloc_valid_i,
  input logic             commit_valid_i,
  input logic             snoop_valid_i,
  input logic             squash_valid_o,
  input logic [CNT_W-1:0] count_q
);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  p_squash_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_o |=> !squash_valid_o);

  p_squash_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(squash_valid_o) |-> $past(snoop_valid_i || commit_valid_i));

  p_flush_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_o |=> (count_q < $past(count_q)));

  p_commit_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && commit_valid_i && !alloc_valid_i && !squash_valid_o && (count_q != '0))
    |=> (count_q == $past(count_q) - CNT_W'(1)));

  p_replay_flush_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && squash_valid_o) |=> (count_q == '0));
endmodule

bind spec_load_guard spec_load_guard_chk #(
  .DEPTH(DEPTH),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .alloc_valid_i (alloc_valid_i),
  .commit_valid_i(commit_valid_i),
  .snoop_valid_i (snoop_valid_i),
  .squash_valid_o(squash_valid_o),
  .count_q       (count_q)
);

// File: tb/spec_load_guard_bench.sv
`timescale 1ns/1ps
module spec_load_guard_bench;
  localparam int DEPTH  = 16;
  localparam int TAG_W  = 6;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mode_i = 1'b0;
  logic              alloc_valid_i = 1'b0;
  logic [TAG_W-1:0]  alloc_tag_i = '0;
  logic              alloc_ready_o;
  logic              exec_valid_i = 1'b0;
  logic [TAG_W-1:0]  exec_tag_i = '0;
  logic [ADDR_W-1:0] exec_addr_i = '0;
  logic [DATA_W-1:0] exec_data_i = '0;
  logic              commit_valid_i = 1'b0;
  logic [DATA_W-1:0] commit_data_i = '0;
  logic              snoop_valid_i = 1'b0;
  logic [ADDR_W-1:0] snoop_addr_i = '0;
  logic              squash_valid_o;
  logic [TAG_W-1:0]  squash_tag_o;

  always #2 clk_i = ~clk_i;

  spec_load_guard u_spec_load_guard (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference: queues ordered oldest first
  int q_tag[$], q_line[$], q_data[$];
  bit q_exe[$];
  bit m_sq = 0;
  int m_tag = 0, m_pos = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit det, mism, cfire, ready_pre;
    int pos, tg;
    ready_pre = (q_tag.size() < DEPTH) && !m_sq;
    if (m_sq) begin
      while (q_tag.size() > m_pos) begin
        void'(q_tag.pop_back()); void'(q_exe.pop_back());
        void'(q_line.pop_back()); void'(q_data.pop_back());
      end
      m_sq = 0;
      return;
    end
    det = 0; pos = 0; tg = 0;
    mism = mode_i && commit_valid_i && (q_tag.size() > 0) && (q_data[0] != int'(commit_data_i));
    if (!mode_i && snoop_valid_i) begin
      for (int k = 0; k < q_tag.size(); k++) begin
        bit h;
        if (k == 0 && commit_valid_i) continue;
        h = (q_exe[k] && q_line[k] == int'(snoop_addr_i >> 6)) ||
            (exec_valid_i && q_tag[k] == int'(exec_tag_i) &&
             (exec_addr_i >> 6) == (snoop_addr_i >> 6));
        if (h && !det) begin det = 1; pos = k; tg = q_tag[k]; end
      end
    end
    if (mism) begin det = 1; pos = 0; tg = q_tag[0]; end
    if (exec_valid_i)
      for (int k = 0; k < q_tag.size(); k++)
        if (q_tag[k] == int'(exec_tag_i)) begin
          q_exe[k] = 1; q_line[k] = int'(exec_addr_i >> 6); q_data[k] = int'(exec_data_i);
        end
    cfire = commit_valid_i && (q_tag.size() > 0) && !mism;
    if (cfire) begin
      void'(q_tag.pop_front()); void'(q_exe.pop_front());
      void'(q_line.pop_front()); void'(q_data.pop_front());
      if (det) pos--;
    end
    if (alloc_valid_i && ready_pre) begin
      q_tag.push_back(int'(alloc_tag_i)); q_exe.push_back(0);
      q_line.push_back(0); q_data.push_back(0);
    end
    m_sq = det; m_tag = tg; m_pos = pos;
  endtask

  task automatic compare();
    bit exp_ready;
    exp_ready = (q_tag.size() < DEPTH) && !m_sq;
    chk(squash_valid_o === m_sq, cur_req, int'(squash_valid_o), int'(m_sq));
    if (m_sq) chk(int'(squash_tag_o) == m_tag, cur_req, int'(squash_tag_o), m_tag);
    chk(alloc_ready_o === exp_ready, cur_req, int'(alloc_ready_o), int'(exp_ready));
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
    alloc_valid_i = 0; exec_valid_i = 0; commit_valid_i = 0; snoop_valid_i = 0;
  endtask

  task automatic set_alloc(input int t);
    alloc_valid_i = 1; alloc_tag_i = TAG_W'(t);
  endtask
  task automatic set_exec(input int t, input int a, input int d);
    exec_valid_i = 1; exec_tag_i = TAG_W'(t); exec_addr_i = ADDR_W'(a); exec_data_i = DATA_W'(d);
  endtask
  task automatic set_commit(input int d);
    commit_valid_i = 1; commit_data_i = DATA_W'(d);
  endtask
  task automatic set_snoop(input int a);
    snoop_valid_i = 1; snoop_addr_i = ADDR_W'(a);
  endtask

  task automatic drain();
    int guard = 0;
    while ((q_tag.size() > 0 || m_sq) && guard < 200) begin
      guard++;
      if (!m_sq) begin
        if (!q_exe[0]) set_exec(q_tag[0], 32'h100, 7);
        else set_commit(q_data[0]);
      end
      cyc();
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    int next_tag;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(squash_valid_o == 0, "R1", int'(squash_valid_o), 0);
    chk(alloc_ready_o == 1, "R1", int'(alloc_ready_o), 1);

    // R2 capacity
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) begin set_alloc(i); cyc(); end
    chk(alloc_ready_o == 0, "R2", int'(alloc_ready_o), 0);
    set_alloc(63); cyc();
    for (int i = 0; i < DEPTH; i++) begin set_exec(i, i * 256, i); cyc(); end
    set_commit(0); cyc();
    chk(alloc_ready_o == 1, "R2", int'(alloc_ready_o), 1);
    drain();

    // R3 same line, other offset
    cur_req = "R3";
    set_alloc(20); cyc(); set_alloc(21); cyc(); set_alloc(22); cyc();
    set_exec(21, 32'h1000, 1); cyc();
    set_exec(20, 32'h2004, 2); cyc();
    set_snoop(32'h3000); cyc();
    chk(squash_valid_o == 0, "R3", int'(squash_valid_o), 0);
    set_snoop(32'h203C); cyc();
    chk(squash_valid_o == 1 && squash_tag_o == 20, "R3", int'(squash_tag_o), 20);
    cyc();
    chk(squash_valid_o == 0, "R3", int'(squash_valid_o), 0);

    // R4 unexecuted loads are blind, same-cycle execute counts
    cur_req = "R4";
    set_alloc(30); cyc(); set_alloc(31); cyc();
    set_exec(31, 32'h3000, 3); cyc();
    set_snoop(32'h5000); cyc();
    chk(squash_valid_o == 0, "R4", int'(squash_valid_o), 0);
    set_exec(30, 32'h5000, 4); set_snoop(32'h5010); cyc();
    chk(squash_valid_o == 1 && squash_tag_o == 30, "R4", int'(squash_tag_o), 30);
    cyc();

    // R5 oldest of several hits, executed out of order
    cur_req = "R5";
    for (int t = 40; t < 44; t++) begin set_alloc(t); cyc(); end
    set_exec(43, 32'h6000, 5); cyc();
    set_exec(41, 32'h6008, 6); cyc();
    set_exec(42, 32'h6010, 7); cyc();
    set_snoop(32'h6020); cyc();
    chk(squash_valid_o == 1 && squash_tag_o == 41, "R5", int'(squash_tag_o), 41);
    // R10 commit and alloc during the squash cycle are ignored
    cur_req = "R10";
    set_commit(0); set_alloc(44); cyc();
    // R6 younger flushed, older kept
    cur_req = "R6";
    set_snoop(32'h6000); cyc();
    chk(squash_valid_o == 0, "R6", int'(squash_valid_o), 0);
    set_exec(40, 32'h7000, 8); cyc();
    set_snoop(32'h7004); cyc();
    chk(squash_valid_o == 1 && squash_tag_o == 40, "R6", int'(squash_tag_o), 40);
    cyc();

    // R7 commit beats snoop on the oldest load
    cur_req = "R7";
    set_alloc(50); cyc(); set_alloc(51); cyc();
    set_exec(50, 32'h8000, 9); cyc();
    set_exec(51, 32'h9000, 10); cyc();
    set_commit(0); set_snoop(32'h8000); cyc();
    chk(squash_valid_o == 0, "R7", int'(squash_valid_o), 0);
    set_snoop(32'h8000); cyc();
    chk(squash_valid_o == 0, "R7", int'(squash_valid_o), 0);
    set_snoop(32'h9000); cyc();
    chk(squash_valid_o == 1 && squash_tag_o == 51, "R7", int'(squash_tag_o), 51);
    cur_req = "R10";
    chk(alloc_ready_o == 0, "R10", int'(alloc_ready_o), 0);
    set_alloc(52); set_snoop(32'h9000); set_exec(51, 32'h9000, 1); cyc();
    chk(squash_valid_o == 0, "R10", int'(squash_valid_o), 0);
    drain();

    // R9 commit data ignored in snoop mode
    cur_req = "R9";
    set_alloc(1); cyc(); set_exec(1, 32'h40, 5); cyc();
    set_commit(99); cyc();
    chk(squash_valid_o == 0, "R9", int'(squash_valid_o), 0);
    drain();

    // R8 replay mode
    mode_i = 1;
    cur_req = "R8";
    set_alloc(60); cyc(); set_alloc(61); cyc(); set_alloc(62); cyc();
    set_exec(60, 32'hA000, 170); cyc();
    set_exec(61, 32'hB000, 187); cyc();
    set_exec(62, 32'hC000, 204); cyc();
    set_commit(170); cyc();
    chk(squash_valid_o == 0, "R8", int'(squash_valid_o), 0);
    cur_req = "R9";
    set_snoop(32'hB000); cyc();
    chk(squash_valid_o == 0, "R9", int'(squash_valid_o), 0);
    cur_req = "R8";
    set_commit(188); cyc();
    chk(squash_valid_o == 1 && squash_tag_o == 61, "R8", int'(squash_tag_o), 61);
    cyc();
    chk(alloc_ready_o == 1, "R8", int'(alloc_ready_o), 1);
    drain();

    // random traffic in both modes against the model
    next_tag = 0;
    for (int md = 0; md < 2; md++) begin
      mode_i = md[0];
      cur_req = md ? "R8" : "R5";
      for (int n = 0; n < 600; n++) begin
        if (!m_sq) begin
          bit do_commit;
          do_commit = (q_tag.size() > 0) && q_exe[0] && ($urandom_range(0, 9) < 3);
          if (do_commit)
            set_commit(($urandom_range(0, 3) == 0) ? (q_data[0] ^ 1) : q_data[0]);
          if (q_tag.size() > 0) begin
            int k;
            k = $urandom_range(0, q_tag.size() - 1);
            if (!q_exe[k] && !(k == 0 && do_commit) && $urandom_range(0, 1) == 1)
              set_exec(q_tag[k], 32'h4000 + $urandom_range(0, 3) * 64 + $urandom_range(0, 63),
                       $urandom_range(0, 3));
          end
          if ($urandom_range(0, 1) == 1) begin
            set_alloc(next_tag); next_tag = (next_tag + 1) % 64;
          end
          if ($urandom_range(0, 4) == 0)
            set_snoop(32'h4000 + $urandom_range(0, 3) * 64 + $urandom_range(0, 63));
        end
        cyc();
      end
      drain();
    end

    finish_up();
  end
endmodule